// File: doc/BRIEF.md
# Single-Bit Boolean Processor

This block is a small engine for single-bit logic. It keeps a one-bit carry, which acts as a one-bit accumulator, and a store of 128 addressable flags held as 16 bytes. Each operation arrives as a 4-bit opcode, a 7-bit flag address and a valid strobe. The engine can force a flag or the carry to 1, force it to 0, or invert it. It can fold a flag, either as stored or inverted, into the carry with AND or OR. It can copy a flag into the carry or the carry into a flag. It also has an atomic test-and-clear, which reports the old value of a flag and clears it.

A host port gives byte-wide access to the same flags, for reading and writing. Each operation returns a result strobe together with the value the addressed flag had before the operation. The carry is visible at all times.

A two-state sequencer paces the work. In `IDLE` the unit is ready. Accepting an opcode that needs two cycles takes the transition `IDLE -> FINISH`. The unit then leaves `FINISH` for `IDLE` unconditionally on the next clock, and it applies the result on that edge. Every other opcode that is accepted completes in `IDLE`, through the transition `IDLE -> IDLE`.

Top module: `bitproc_unit`

## Requirements
- R1: After reset the carry reads 0, all 128 flags read 0, `op_ready` is 1 and `res_valid` is 0.
- R2: Flag address n refers to byte n[6:3], bit n[2:0] of that byte. `host_rdata` always shows the byte selected by `host_addr`.
- R3: The carry opcodes complete in one cycle: 1 forces the carry to 1, 2 forces it to 0, 3 inverts it. An opcode accepted at edge k updates `carry_out` at edge k, and `res_valid` is high for the one cycle that follows.
- R4: The flag opcodes complete in one cycle: 4 sets the flag, 5 clears it, 6 inverts it.
- R5: Opcodes 7 (carry AND flag) and 9 (carry OR flag) take two cycles. `op_ready` is low for exactly the one cycle after the opcode is accepted, and the carry and result update at the following edge.
- R6: Opcodes 8 (carry AND NOT flag) and 10 (carry OR NOT flag) take two cycles and never change the addressed flag.
- R7: Opcode 11 copies the flag into the carry in one cycle. Opcode 12 writes the carry into the flag in two cycles.
- R8: Opcode 13, test-and-clear, takes two cycles. It reports the old flag value on `res_bit` and leaves the flag cleared. On a flag that is already 0 it performs no write and reports 0.
- R9: An opcode presented while `op_ready` is 0 is ignored.
- R10: A host write updates its byte at the next edge. If an operation commits a flag write into the same byte on that edge, the host write is dropped and the flag write is kept.
- R11: Opcode 0 and the unused codes 14 and 15 complete in one cycle, change no state and report 0.
- R12: For opcodes 4 to 13, `res_bit` is the value the addressed flag had in the commit cycle, before the operation. For all other opcodes it is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| op_code | input | 4 | Operation code |
| bit_addr | input | 7 | Flag address |
| op_ready | output | 1 | High when a new operation can be accepted |
| carry_out | output | 1 | Carry flag |
| res_valid | output | 1 | One-cycle pulse after an operation commits |
| res_bit | output | 1 | Pre-operation flag value |
| host_addr | input | 4 | Host byte select |
| host_we | input | 1 | Host byte write enable |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Selected byte of the flag store |

## Verification
The property that an inverted-operand opcode leaves the store unchanged assumes no host write happens in its commit cycle. The test-and-clear property makes the same assumption, so both are qualified by `host_we` being low. The stimulus keeps its strobes stable across each clock edge and changes them only shortly after an edge. The random phase deliberately drives opcodes while the unit is busy and drives host writes that collide with flag writes. The cycle-level model in the bench resolves both cases with the rules of R9 and R10.

// File: rtl/bitproc_pkg.sv
package bitproc_pkg;

    typedef enum logic [3:0] {
        OP_NOP    = 4'd0,
        OP_SETC   = 4'd1,
        OP_CLRC   = 4'd2,
        OP_CPLC   = 4'd3,
        OP_SETB   = 4'd4,
        OP_CLRB   = 4'd5,
        OP_CPLB   = 4'd6,
        OP_ANDC   = 4'd7,
        OP_ANDCN  = 4'd8,
        OP_ORC    = 4'd9,
        OP_ORCN   = 4'd10,
        OP_LDC    = 4'd11,
        OP_STC    = 4'd12,
        OP_TSTCLR = 4'd13
    } bp_op_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_FINISH = 1'b1
    } bp_state_e;

    function automatic logic is_two_cycle(input logic [3:0] op);
        return (op == OP_ANDC) || (op == OP_ANDCN) || (op == OP_ORC) ||
               (op == OP_ORCN) || (op == OP_STC)   || (op == OP_TSTCLR);
    endfunction

    function automatic logic uses_flag(input logic [3:0] op);
        return (op >= 4'd4) && (op <= 4'd13);
    endfunction

endpackage

// File: rtl/bitproc_store.sv
module bitproc_store #(
    parameter int NUM_BYTES = 16,
    localparam int NFLAGS = NUM_BYTES * 8,
    localparam int BA_W = $clog2(NFLAGS),
    localparam int BY_W = $clog2(NUM_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BA_W-1:0]   flag_addr,
    input  logic              flag_we,
    input  logic              flag_wdata,
    output logic              flag_rdata,
    input  logic [BY_W-1:0]   host_addr,
    input  logic              host_we,
    input  logic [7:0]        host_wdata,
    output logic [7:0]        host_rdata,
    output logic [NFLAGS-1:0] flags
);

    logic [BY_W-1:0] flag_byte;
    logic [2:0]      flag_pos;

    assign flag_byte = flag_addr[BA_W-1:3];
    assign flag_pos  = flag_addr[2:0];

    generate
        for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
            logic [7:0] byte_q;
            logic       bit_hit;
            logic       host_hit;

            assign bit_hit  = flag_we && (flag_byte == BY_W'(g));
            assign host_hit = host_we && (host_addr == BY_W'(g));

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    byte_q <= '0;
                end else if (bit_hit) begin
                    byte_q[flag_pos] <= flag_wdata;
                end else if (host_hit) begin
                    byte_q <= host_wdata;
                end
            end

            assign flags[g*8 +: 8] = byte_q;
        end
    endgenerate

    assign flag_rdata = flags[flag_addr];
    assign host_rdata = flags[{host_addr, 3'b000} +: 8];

endmodule

// File: rtl/bitproc_alu.sv
module bitproc_alu
    import bitproc_pkg::*;
(
    input  logic [3:0] op,
    input  logic       carry,
    input  logic       flag_val,
    output logic       c_we,
    output logic       c_new,
    output logic       b_we,
    output logic       b_new
);

    always_comb begin
        c_we  = 1'b0;
        c_new = carry;
        b_we  = 1'b0;
        b_new = flag_val;
        case (bp_op_e'(op))
            OP_SETC:   begin c_we = 1'b1; c_new = 1'b1;               end
            OP_CLRC:   begin c_we = 1'b1; c_new = 1'b0;               end
            OP_CPLC:   begin c_we = 1'b1; c_new = ~carry;             end
            OP_SETB:   begin b_we = 1'b1; b_new = 1'b1;               end
            OP_CLRB:   begin b_we = 1'b1; b_new = 1'b0;               end
            OP_CPLB:   begin b_we = 1'b1; b_new = ~flag_val;          end
            OP_ANDC:   begin c_we = 1'b1; c_new = carry & flag_val;   end
            OP_ANDCN:  begin c_we = 1'b1; c_new = carry & ~flag_val;  end
            OP_ORC:    begin c_we = 1'b1; c_new = carry | flag_val;   end
            OP_ORCN:   begin c_we = 1'b1; c_new = carry | ~flag_val;  end
            OP_LDC:    begin c_we = 1'b1; c_new = flag_val;           end
            OP_STC:    begin b_we = 1'b1; b_new = carry;              end
            OP_TSTCLR: begin b_we = flag_val; b_new = 1'b0;           end
            default:   begin end
        endcase
    end

endmodule

// File: rtl/bitproc_ctrl.sv
module bitproc_ctrl
    import bitproc_pkg::*;
#(
    parameter int BA_W = 7
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [BA_W-1:0] bit_addr,
    output logic            op_ready,
    output logic [3:0]      cur_op,
    output logic [BA_W-1:0] cur_addr,
    output logic            commit
);

    bp_state_e       state, state_nx;
    logic [3:0]      op_q;
    logic [BA_W-1:0] addr_q;
    logic            accept_two;

    assign accept_two = (state == ST_IDLE) && op_valid && is_two_cycle(op_code);

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (accept_two) state_nx = ST_FINISH;
            ST_FINISH: state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            op_q   <= '0;
            addr_q <= '0;
        end else begin
            state <= state_nx;
            if (accept_two) begin
                op_q   <= op_code;
                addr_q <= bit_addr;
            end
        end
    end

    always_comb begin
        unique case (state)
            ST_IDLE: begin
                op_ready = 1'b1;
                cur_op   = op_code;
                cur_addr = bit_addr;
                commit   = op_valid && !is_two_cycle(op_code);
            end
            ST_FINISH: begin
                op_ready = 1'b0;
                cur_op   = op_q;
                cur_addr = addr_q;
                commit   = 1'b1;
            end
        endcase
    end

    AST_FINISH_RETURNS: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_FINISH) |=> (state == ST_IDLE)) else $error("finish stuck"); // R5
    AST_BUSY_AFTER_TWO: assert property (@(posedge clk) disable iff (!rst_n)
        accept_two |=> !op_ready) else $error("not busy after two-cycle op"); // R5
    AST_BUSY_NO_COMMIT_NEW: assert property (@(posedge clk) disable iff (!rst_n)
        (!op_ready) |-> (cur_op == op_q)) else $error("busy op taken"); // R9

endmodule

// File: rtl/bitproc_unit.sv
module bitproc_unit
    import bitproc_pkg::*;
#(
    parameter int NUM_BYTES = 16,
    localparam int NFLAGS = NUM_BYTES * 8,
    localparam int BA_W = $clog2(NFLAGS),
    localparam int BY_W = $clog2(NUM_BYTES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            op_valid,
    input  logic [3:0]      op_code,
    input  logic [BA_W-1:0] bit_addr,
    output logic            op_ready,
    output logic            carry_out,
    output logic            res_valid,
    output logic            res_bit,
    input  logic [BY_W-1:0] host_addr,
    input  logic            host_we,
    input  logic [7:0]      host_wdata,
    output logic [7:0]      host_rdata
);

    logic [3:0]        cur_op;
    logic [BA_W-1:0]   cur_addr;
    logic              commit;
    logic              flag_val;
    logic              c_we, c_new, b_we, b_new;
    logic              carry_q;
    logic [NFLAGS-1:0] flags;

    bitproc_ctrl #(.BA_W(BA_W)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .op_valid (op_valid),
        .op_code  (op_code),
        .bit_addr (bit_addr),
        .op_ready (op_ready),
        .cur_op   (cur_op),
        .cur_addr (cur_addr),
        .commit   (commit)
    );

    bitproc_alu u_alu (
        .op       (cur_op),
        .carry    (carry_q),
        .flag_val (flag_val),
        .c_we     (c_we),
        .c_new    (c_new),
        .b_we     (b_we),
        .b_new    (b_new)
    );

    bitproc_store #(.NUM_BYTES(NUM_BYTES)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .flag_addr  (cur_addr),
        .flag_we    (commit && b_we),
        .flag_wdata (b_new),
        .flag_rdata (flag_val),
        .host_addr  (host_addr),
        .host_we    (host_we),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .flags      (flags)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            carry_q   <= 1'b0;
            res_valid <= 1'b0;
            res_bit   <= 1'b0;
        end else begin
            res_valid <= commit;
            if (commit) begin
                res_bit <= uses_flag(cur_op) ? flag_val : 1'b0;
                if (c_we) carry_q <= c_new;
            end
        end
    end

    assign carry_out = carry_q;

    AST_SETC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_ready && op_code == OP_SETC) |=> carry_out) else $error("set carry"); // R3
    AST_INV_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !host_we && (cur_op == OP_ANDCN || cur_op == OP_ORCN)) |=> $stable(flags))
        else $error("inverted form wrote a flag"); // R6
    AST_TSTCLR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && !host_we && cur_op == OP_TSTCLR) |=> !flags[$past(cur_addr)])
        else $error("test-and-clear left flag set"); // R8
    AST_NOP_KEEPS_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
        (commit && (cur_op == OP_NOP || cur_op > OP_TSTCLR)) |=> $stable(carry_out))
        else $error("nop changed carry"); // R11

endmodule

// File: tb/sim_bitproc_unit.sv
`timescale 1ns/1ps
module sim_bitproc_unit;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_code = '0;
    logic [6:0] bit_addr = '0;
    logic [3:0] host_addr = '0;
    logic       host_we = 1'b0;
    logic [7:0] host_wdata = '0;
    logic       op_ready, carry_out, res_valid, res_bit;
    logic [7:0] host_rdata;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    string phase = "R1";

    always #5 clk = ~clk;

    bitproc_unit u0 (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .bit_addr(bit_addr), .op_ready(op_ready), .carry_out(carry_out),
        .res_valid(res_valid), .res_bit(res_bit), .host_addr(host_addr),
        .host_we(host_we), .host_wdata(host_wdata), .host_rdata(host_rdata)
    );

    // behavioural reference model
    logic [127:0] m_flags;
    logic         m_c, m_busy, m_rv, m_rb;
    int           m_op, m_addr;

    function automatic bit two_cyc(int op);
        return op inside {7, 8, 9, 10, 12, 13};
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_flags = '0; m_c = 0; m_busy = 0; m_rv = 0; m_rb = 0; m_op = 0; m_addr = 0;
        end else begin
            automatic bit doit;
            automatic bit wr;
            automatic bit nb;
            automatic bit b;
            automatic int eop;
            automatic int ea;
            doit = 0; wr = 0; nb = 0; eop = 0; ea = 0;
            if (m_busy) begin
                doit = 1; eop = m_op; ea = m_addr; m_busy = 0;
            end else if (op_valid) begin
                if (two_cyc(int'(op_code))) begin
                    m_busy = 1; m_op = int'(op_code); m_addr = int'(bit_addr);
                end else begin
                    doit = 1; eop = int'(op_code); ea = int'(bit_addr);
                end
            end
            m_rv = doit;
            if (doit) begin
                b = m_flags[ea];
                m_rb = (eop >= 4 && eop <= 13) ? b : 1'b0;
                case (eop)
                    1: m_c = 1;
                    2: m_c = 0;
                    3: m_c = ~m_c;
                    4: begin wr = 1; nb = 1; end
                    5: begin wr = 1; nb = 0; end
                    6: begin wr = 1; nb = ~b; end
                    7: m_c = m_c & b;
                    8: m_c = m_c & ~b;
                    9: m_c = m_c | b;
                    10: m_c = m_c | ~b;
                    11: m_c = b;
                    12: begin wr = 1; nb = m_c; end
                    13: if (b) begin wr = 1; nb = 0; end
                    default: ;
                endcase
            end
            if (host_we && !(wr && (ea / 8) == int'(host_addr)))
                m_flags[int'(host_addr)*8 +: 8] = host_wdata;
            if (wr) m_flags[ea] = nb;
        end
    end

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R9", "op_ready", op_ready, !m_busy);
            chk("R3", "carry_out", carry_out, m_c);
            chk("R5", "res_valid", res_valid, m_rv);
            if (m_rv) chk("R12", "res_bit", res_bit, m_rb);
            chk("R2", "host_rdata", host_rdata, m_flags[int'(host_addr)*8 +: 8]);
        end
    end

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic issue(int op, int a);
        while (!op_ready) tick();
        op_valid = 1; op_code = 4'(op); bit_addr = 7'(a);
        tick();
        op_valid = 0;
        if (two_cyc(op)) tick();
    endtask

    task automatic hwrite(int a, int d);
        host_we = 1; host_addr = 4'(a); host_wdata = 8'(d);
        tick();
        host_we = 0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual hung expected done");
            finished = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1;
        #1;
        // R1 reset state
        chk("R1", "carry", carry_out, 0);
        chk("R1", "ready", op_ready, 1);
        chk("R1", "res_valid", res_valid, 0);
        for (int i = 0; i < 16; i++) begin
            host_addr = 4'(i); #0.1;
            chk("R1", "byte", host_rdata, 0);
        end
        tick();
        // R2 mapping: flag 43 -> byte 5 bit 3
        phase = "R2";
        issue(4, 43);
        host_addr = 5; #1;
        chk("R2", "mapped byte", host_rdata, 8'h08);
        chk("R4", "res_bit set old", res_bit, 0);
        issue(6, 43); #1;
        chk("R4", "cpl result", host_rdata, 8'h00);
        chk("R12", "cpl old value", res_bit, 1);
        // R3 carry ops
        issue(1, 0); #1; chk("R3", "setc", carry_out, 1);
        issue(3, 0); #1; chk("R3", "cplc", carry_out, 0);
        // R5 and R6
        hwrite(2, 8'h01);
        issue(1, 0);
        issue(8, 16); #1;
        chk("R6", "andcn carry", carry_out, 0);
        host_addr = 2; #1;
        chk("R6", "flag untouched", host_rdata, 8'h01);
        issue(10, 16); #1; chk("R6", "orcn carry", carry_out, 0);
        issue(9, 16); #1; chk("R5", "orc carry", carry_out, 1);
        issue(7, 17); #1; chk("R5", "andc carry", carry_out, 0);
        // R7
        issue(11, 16); #1; chk("R7", "ldc", carry_out, 1);
        issue(12, 23); host_addr = 2; #1; chk("R7", "stc", host_rdata, 8'h81);
        // R8
        issue(13, 23); #1;
        chk("R8", "tstclr report", res_bit, 1);
        chk("R8", "tstclr cleared", host_rdata, 8'h01);
        issue(13, 23); #1;
        chk("R8", "tstclr clear report", res_bit, 0);
        // R11
        issue(15, 16); #1; chk("R11", "nop res", res_bit, 0);
        // R9 busy ignore
        op_valid = 1; op_code = 7; bit_addr = 16; tick();
        op_code = 5; bit_addr = 16; tick();
        op_valid = 0; tick();
        host_addr = 2; #1; chk("R9", "busy op ignored", host_rdata, 8'h01);
        // R10 collision
        op_valid = 1; op_code = 4; bit_addr = 7'(5*8+1);
        host_we = 1; host_addr = 5; host_wdata = 8'hF0;
        tick();
        op_valid = 0; host_we = 0; #1;
        chk("R10", "collision", host_rdata, 8'h02);
        hwrite(5, 8'h3C); #1; chk("R10", "host write", host_rdata, 8'h3C);
        // random phase
        phase = "random";
        for (int n = 0; n < 4000; n++) begin
            op_valid = ($urandom_range(0, 3) != 0);
            op_code = 4'($urandom_range(0, 15));
            bit_addr = 7'($urandom_range(0, 127));
            host_we = ($urandom_range(0, 4) == 0);
            host_addr = 4'($urandom_range(0, 15));
            host_wdata = 8'($urandom_range(0, 255));
            tick();
        end
        op_valid = 0; host_we = 0;
        tick(); tick();
        for (int i = 0; i < 16; i++) begin
            host_addr = 4'(i); #1;
            chk("R2", "final byte", host_rdata, m_flags[i*8 +: 8]);
        end
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule